// File: doc/BRIEF.md
# Bus-Watch Debug Trigger Unit

The unit watches every access on a processor bus with two comparators, A and B, and decides when a debug trigger occurs. Nine encoded trigger conditions are available. Four compare one access against A, B or both: A alone, A or B, A with a data value, A without a data value. Two test an address range. Two are two-step sequences, and one reports every B access as an event. A trigger can be raised by the access itself (force), or by a tag placed on an opcode fetch that fires only when that opcode is reported as executed.

Around the trigger, the unit drives the write strobe and data of an external eight-entry trace buffer. In a begin trace, bus addresses are recorded after the trigger until the buffer is full. In an end trace, addresses are recorded continuously, with the buffer wrapping, until the trigger stops the run. In the event modes, the bus data of each qualifying B access is recorded. Software sets up the unit through a small register port. Writing the arm command starts a run. The unit disarms itself and raises a done flag when the run completes.

Top module: `bus_trigger_unit`

## Requirements
- R1: After reset `armed` and `done` are 0, and the control and command/status registers read as 0.
- R2: Control register (select 0): bit 7 selects tag (1) or force (0), bit 6 selects begin (1) or end (0) trace, and bits 3:0 hold the mode. Bits 5:4 and all bits above 7 always read 0. Select 1 is comparator A and select 2 is comparator B.
- R3: A write to the control register while armed is ignored. The comparator registers accept writes at any time.
- R4: Mode codes: 0 addr==A; 1 addr==A or addr==B; 2 A then B; 3 event-only B; 4 A then event-only B; 5 addr==A and data==B[7:0]; 6 addr==A and data!=B[7:0]; 7 A<=addr<=B; 8 addr<A or addr>B.
- R5: Mode codes 9 to 15 never raise `trig_evt`.
- R6: In modes 2 and 4, a qualified A match sets a sequence flag. B matches count only while the flag is set. The flag is cleared by arming and by disarming.
- R7: In modes 3 and 4, each qualifying B match pulses `trig_evt` and writes the access data, zero-extended, as one buffer entry. The begin/end bit is ignored. The run ends after 8 entries.
- R8: In a begin trace, each valid access in the cycles after the trigger cycle is written with its address. After the 8th entry the unit disarms and sets `done`.
- R9: In an end trace, every valid access while armed is written, including the triggering access. The unit disarms and sets `done` on the edge after the trigger.
- R10: In force mode, `trig_evt` is asserted combinationally in the same cycle as the matching access.
- R11: In tag mode, only a valid fetch that matches records a tag. `trig_evt` fires when `exec_go` arrives while a tag is held. `flush` discards the tag. An `exec_go` in the same cycle as a new fetch acts on the tag that was held before that fetch.
- R12: Writing select 3 with bit 0 = 1 arms the unit and clears `done`. Writing bit 0 = 0 disarms it and leaves `done` unchanged. Select 3 reads bit 0 = armed and bit 1 = done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 comparator A, 2 comparator B, 3 command/status |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Read data of the selected register |
| bus_valid | input | 1 | A bus access happens this cycle |
| bus_fetch | input | 1 | The access is an opcode fetch |
| bus_addr | input | ADDR_W | Access address |
| bus_data | input | DATA_W | Access data |
| exec_go | input | 1 | The opcode that was tagged last has executed |
| flush | input | 1 | Pipeline flush; the held tag is discarded |
| trig_evt | output | 1 | Trigger event pulse |
| fifo_we | output | 1 | Trace buffer write strobe |
| fifo_wdata | output | ADDR_W | Trace buffer write data |
| armed | output | 1 | A run is in progress |
| done | output | 1 | The last run completed |

## Verification
The bench uses the default parameters: 16-bit addresses, 8-bit data and an 8-entry buffer. With these values, all sixteen mode codes can be swept against probe addresses on, inside and outside the comparator window, with matching and non-matching data. The short buffer lets each begin, end and event run fill or stop within a few dozen accesses. The comparators are placed so that the range boundaries and the data compare against the low byte of B each meet a probe exactly.

// File: rtl/btu_pkg.sv
// Shared constants of the bus-watch trigger unit: register selects,
// control field positions and trigger mode codes.
package btu_pkg;
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_CMPA = 2'd1;
    localparam logic [1:0] SEL_CMPB = 2'd2;
    localparam logic [1:0] SEL_CMD  = 2'd3;

    localparam int CTRL_TAG_BIT   = 7;
    localparam int CTRL_BEGIN_BIT = 6;

    localparam logic [3:0] MODE_A_ONLY     = 4'd0;
    localparam logic [3:0] MODE_A_OR_B     = 4'd1;
    localparam logic [3:0] MODE_A_THEN_B   = 4'd2;
    localparam logic [3:0] MODE_EVENT_B    = 4'd3;
    localparam logic [3:0] MODE_A_THEN_EVB = 4'd4;
    localparam logic [3:0] MODE_A_AND_BD   = 4'd5;
    localparam logic [3:0] MODE_A_NOT_BD   = 4'd6;
    localparam logic [3:0] MODE_INSIDE     = 4'd7;
    localparam logic [3:0] MODE_OUTSIDE    = 4'd8;
endpackage

// File: rtl/btu_regs.sv
// Register block: holds the control fields and both comparators, and
// decodes the arm/disarm command. Assumes at most one write per cycle.
// The control register is locked while a run is armed.
module btu_regs
    import btu_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic              armed,
    input  logic              done,
    output logic              tag_mode,
    output logic              begin_sel,
    output logic [3:0]        mode,
    output logic [ADDR_W-1:0] cmp_a,
    output logic [ADDR_W-1:0] cmp_b,
    output logic              arm_req,
    output logic              disarm_req,
    output logic [ADDR_W-1:0] reg_rdata
);
    logic ctrl_wr;

    assign ctrl_wr = reg_we && (reg_sel == SEL_CTRL) && !armed;

    // Store the register fields; the control write is dropped while armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_mode  <= 1'b0;
            begin_sel <= 1'b0;
            mode      <= 4'd0;
            cmp_a     <= '0;
            cmp_b     <= '0;
        end else begin
            if (ctrl_wr) begin
                tag_mode  <= reg_wdata[CTRL_TAG_BIT];
                begin_sel <= reg_wdata[CTRL_BEGIN_BIT];
                mode      <= reg_wdata[3:0];
            end
            if (reg_we && reg_sel == SEL_CMPA) cmp_a <= reg_wdata;
            if (reg_we && reg_sel == SEL_CMPB) cmp_b <= reg_wdata;
        end
    end

    // Decode the command register into arm and disarm pulses.
    always_comb begin
        arm_req    = reg_we && (reg_sel == SEL_CMD) && reg_wdata[0];
        disarm_req = reg_we && (reg_sel == SEL_CMD) && !reg_wdata[0];
    end

    // Read multiplexer; unused control bits read as zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_CTRL: begin
                reg_rdata[CTRL_TAG_BIT]   = tag_mode;
                reg_rdata[CTRL_BEGIN_BIT] = begin_sel;
                reg_rdata[3:0]            = mode;
            end
            SEL_CMPA: reg_rdata = cmp_a;
            SEL_CMPB: reg_rdata = cmp_b;
            default: begin
                reg_rdata[0] = armed;
                reg_rdata[1] = done;
            end
        endcase
    end

    // R3
    ctrl_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == SEL_CTRL && armed) |=>
            ($stable(mode) && $stable(tag_mode) && $stable(begin_sel)));
endmodule

// File: rtl/btu_match.sv
// Comparator and mode decoder: for one bus access, computes the raw A-side
// and B-side hits that the selected mode defines. Purely combinational;
// the data compare uses the low DATA_W bits of comparator B.
module btu_match
    import btu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic [3:0]        mode,
    input  logic [ADDR_W-1:0] cmp_a,
    input  logic [ADDR_W-1:0] cmp_b,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    output logic              hit_a,
    output logic              hit_b
);
    logic eq_a, eq_b, eq_bd, in_win;

    // Raw comparisons shared by all modes.
    always_comb begin
        eq_a   = (bus_addr == cmp_a);
        eq_b   = (bus_addr == cmp_b);
        eq_bd  = (bus_data == cmp_b[DATA_W-1:0]);
        in_win = (bus_addr >= cmp_a) && (bus_addr <= cmp_b);
    end

    // Map the mode onto the A-side and B-side hits.
    always_comb begin
        hit_a = 1'b0;
        hit_b = 1'b0;
        case (mode)
            MODE_A_ONLY:     hit_a = eq_a;
            MODE_A_OR_B:     hit_a = eq_a || eq_b;
            MODE_A_THEN_B:   begin hit_a = eq_a; hit_b = eq_b; end
            MODE_EVENT_B:    hit_b = eq_b;
            MODE_A_THEN_EVB: begin hit_a = eq_a; hit_b = eq_b; end
            MODE_A_AND_BD:   hit_a = eq_a && eq_bd;
            MODE_A_NOT_BD:   hit_a = eq_a && !eq_bd;
            MODE_INSIDE:     hit_a = in_win;
            MODE_OUTSIDE:    hit_a = !in_win;
            default:         ;
        endcase
    end
endmodule

// File: rtl/btu_qualify.sv
// Force/tag qualification. In force mode a hit on a valid access becomes
// an event at once. In tag mode a matching fetch records a single tag,
// which becomes an event on exec_go and is dropped on flush. Assumes
// exec_go refers to the most recently tagged opcode.
module btu_qualify #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tag_mode,
    input  logic              armed,
    input  logic              bus_valid,
    input  logic              bus_fetch,
    input  logic              hit_a,
    input  logic              hit_b,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              exec_go,
    input  logic              flush,
    output logic              ev_a,
    output logic              ev_b,
    output logic [DATA_W-1:0] ev_data
);
    logic              tag_v, tag_a, tag_b;
    logic [DATA_W-1:0] tag_d;
    logic              record;

    assign record = tag_mode && bus_valid && bus_fetch && (hit_a || hit_b);

    // Hold the pending tag; a new fetch wins over an exec/flush of the old one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_v <= 1'b0;
            tag_a <= 1'b0;
            tag_b <= 1'b0;
            tag_d <= '0;
        end else if (!armed) begin
            tag_v <= 1'b0;
        end else if (record) begin
            tag_v <= 1'b1;
            tag_a <= hit_a;
            tag_b <= hit_b;
            tag_d <= bus_data;
        end else if (exec_go || flush) begin
            tag_v <= 1'b0;
        end
    end

    // Select the event source for the current trigger type.
    always_comb begin
        if (tag_mode) begin
            ev_a    = armed && exec_go && tag_v && tag_a;
            ev_b    = armed && exec_go && tag_v && tag_b;
            ev_data = tag_d;
        end else begin
            ev_a    = armed && bus_valid && hit_a;
            ev_b    = armed && bus_valid && hit_b;
            ev_data = bus_data;
        end
    end

    // R11
    flush_drops_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !(bus_valid && bus_fetch)) |=> !tag_v);
endmodule

// File: rtl/btu_seq.sv
// Run control: arm state, two-step sequence flag, begin/end trace control,
// trace buffer write strobe and entry counting. Assumes the control fields
// do not change while armed.
module btu_seq
    import btu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_req,
    input  logic              disarm_req,
    input  logic [3:0]        mode,
    input  logic              begin_sel,
    input  logic              ev_a,
    input  logic              ev_b,
    input  logic [DATA_W-1:0] ev_data,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              armed,
    output logic              done,
    output logic              trig_evt,
    output logic              fifo_we,
    output logic [ADDR_W-1:0] fifo_wdata
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DEPTH - 1);

    logic             seq_q, started_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ev_only, two_step, begin_run;
    logic             eo_hit, main_hit, last_entry, finish;

    // Classify the mode and form the trigger condition.
    always_comb begin
        ev_only   = (mode == MODE_EVENT_B) || (mode == MODE_A_THEN_EVB);
        two_step  = (mode == MODE_A_THEN_B) || (mode == MODE_A_THEN_EVB);
        begin_run = ev_only || begin_sel;
        eo_hit    = ev_only && ev_b && ((mode == MODE_EVENT_B) || seq_q);
        main_hit  = (mode == MODE_A_THEN_B) ? (seq_q && ev_b) : (!ev_only && ev_a);
        trig_evt  = armed && (ev_only ? eo_hit : (main_hit && !started_q));
    end

    // Drive the trace buffer according to the trace direction.
    always_comb begin
        if (ev_only) begin
            fifo_we    = armed && eo_hit;
            fifo_wdata = ADDR_W'(ev_data);
        end else if (begin_run) begin
            fifo_we    = armed && started_q && bus_valid;
            fifo_wdata = bus_addr;
        end else begin
            fifo_we    = armed && bus_valid;
            fifo_wdata = bus_addr;
        end
        last_entry = begin_run && fifo_we && (cnt_q == LAST);
        finish     = last_entry || (!begin_run && trig_evt);
    end

    // Advance arm, sequence, capture and count state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed     <= 1'b0;
            done      <= 1'b0;
            seq_q     <= 1'b0;
            started_q <= 1'b0;
            cnt_q     <= '0;
        end else if (arm_req) begin
            armed     <= 1'b1;
            done      <= 1'b0;
            seq_q     <= 1'b0;
            started_q <= 1'b0;
            cnt_q     <= '0;
        end else if (disarm_req) begin
            armed     <= 1'b0;
            seq_q     <= 1'b0;
            started_q <= 1'b0;
        end else if (armed) begin
            if (finish) begin
                armed     <= 1'b0;
                done      <= 1'b1;
                seq_q     <= 1'b0;
                started_q <= 1'b0;
            end else begin
                if (two_step && ev_a) seq_q <= 1'b1;
                if (!ev_only && begin_run && trig_evt) started_q <= 1'b1;
                if (begin_run && fifo_we) cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R9
    end_trace_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!begin_run && trig_evt && !arm_req && !disarm_req) |=> (!armed && done));
    // R12
    armed_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> !done);
    // R5
    bad_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode > MODE_OUTSIDE) |-> !trig_evt);
    // R8
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(DEPTH));
    // R6
    seq_idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !seq_q);
endmodule

// File: rtl/bus_trigger_unit.sv
// Top of the bus-watch debug trigger unit: register block, comparator and
// mode decoder, force/tag qualification and run control. Assumes one bus
// access per cycle at most and ADDR_W >= DATA_W.
module bus_trigger_unit #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              bus_valid,
    input  logic              bus_fetch,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              exec_go,
    input  logic              flush,
    output logic              trig_evt,
    output logic              fifo_we,
    output logic [ADDR_W-1:0] fifo_wdata,
    output logic              armed,
    output logic              done
);
    logic              tag_mode, begin_sel, arm_req, disarm_req;
    logic [3:0]        mode;
    logic [ADDR_W-1:0] cmp_a, cmp_b;
    logic              hit_a, hit_b, ev_a, ev_b;
    logic [DATA_W-1:0] ev_data;

    btu_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .armed(armed), .done(done),
        .tag_mode(tag_mode), .begin_sel(begin_sel), .mode(mode),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .arm_req(arm_req),
        .disarm_req(disarm_req), .reg_rdata(reg_rdata)
    );

    btu_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
        .mode(mode), .cmp_a(cmp_a), .cmp_b(cmp_b), .bus_addr(bus_addr),
        .bus_data(bus_data), .hit_a(hit_a), .hit_b(hit_b)
    );

    btu_qualify #(.DATA_W(DATA_W)) u_qual (
        .clk(clk), .rst_n(rst_n), .tag_mode(tag_mode), .armed(armed),
        .bus_valid(bus_valid), .bus_fetch(bus_fetch), .hit_a(hit_a),
        .hit_b(hit_b), .bus_data(bus_data), .exec_go(exec_go),
        .flush(flush), .ev_a(ev_a), .ev_b(ev_b), .ev_data(ev_data)
    );

    btu_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_seq (
        .clk(clk), .rst_n(rst_n), .arm_req(arm_req), .disarm_req(disarm_req),
        .mode(mode), .begin_sel(begin_sel), .ev_a(ev_a), .ev_b(ev_b),
        .ev_data(ev_data), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .armed(armed), .done(done), .trig_evt(trig_evt),
        .fifo_we(fifo_we), .fifo_wdata(fifo_wdata)
    );
endmodule

// File: tb/test_bus_trigger_unit.sv
module test_bus_trigger_unit;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam logic [AW-1:0] CA = 16'h0040;
    localparam logic [AW-1:0] CB = 16'h0060;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_sel = 2'd0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;
    logic          bus_valid = 1'b0, bus_fetch = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_data = '0;
    logic          exec_go = 1'b0, flush = 1'b0;
    logic          trig_evt, fifo_we, armed, done;
    logic [AW-1:0] fifo_wdata;

    int n_chk = 0;
    int n_bad = 0;
    logic          s_trig, s_we, s_armed;
    logic [AW-1:0] s_wd, rv;

    bus_trigger_unit i_bus_trigger_unit (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
        .bus_fetch(bus_fetch), .bus_addr(bus_addr), .bus_data(bus_data),
        .exec_go(exec_go), .flush(flush), .trig_evt(trig_evt),
        .fifo_we(fifo_we), .fifo_wdata(fifo_wdata), .armed(armed), .done(done)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic drive(input logic v, input logic f, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input logic eg, input logic fl);
        @(negedge clk);
        reg_we = 1'b0; bus_valid = v; bus_fetch = f; bus_addr = a;
        bus_data = d; exec_go = eg; flush = fl;
        #1;
        s_trig = trig_evt; s_we = fifo_we; s_wd = fifo_wdata; s_armed = armed;
    endtask

    task automatic reg_wr(input logic [1:0] sel, input logic [AW-1:0] d);
        @(negedge clk);
        bus_valid = 1'b0; exec_go = 1'b0; flush = 1'b0;
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    endtask

    task automatic reg_rd(input logic [1:0] sel);
        @(negedge clk);
        bus_valid = 1'b0; exec_go = 1'b0; flush = 1'b0;
        reg_we = 1'b0; reg_sel = sel;
        #1;
        rv = reg_rdata;
    endtask

    function automatic logic exp1(input int m, input logic [AW-1:0] a, input logic [DW-1:0] d);
        case (m)
            0: return a == CA;
            1: return (a == CA) || (a == CB);
            3: return a == CB;
            5: return (a == CA) && (d == CB[DW-1:0]);
            6: return (a == CA) && (d != CB[DW-1:0]);
            7: return (a >= CA) && (a <= CB);
            8: return (a < CA) || (a > CB);
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [AW-1:0] probes [6];
        probes[0] = 16'h003F; probes[1] = 16'h0040; probes[2] = 16'h0041;
        probes[3] = 16'h0050; probes[4] = 16'h0060; probes[5] = 16'h0061;

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        drive(0, 0, '0, '0, 0, 0);
        check("R1 armed", {31'b0, s_armed}, 0);
        check("R1 done", {31'b0, done}, 0);
        reg_rd(2'd0); check("R1 ctrl", {16'b0, rv}, 0);
        reg_rd(2'd3); check("R1 status", {16'b0, rv}, 0);

        // R2 / R3 field layout and lock
        reg_wr(2'd0, 16'hFFFF);
        reg_rd(2'd0); check("R2 ctrl readback", {16'b0, rv}, 32'h00CF);
        reg_wr(2'd3, 16'h0001);
        reg_rd(2'd3); check("R12 status armed", {16'b0, rv}, 1);
        reg_wr(2'd0, 16'h0000);
        reg_rd(2'd0); check("R3 ctrl locked", {16'b0, rv}, 32'h00CF);
        reg_wr(2'd1, 16'h1234);
        reg_rd(2'd1); check("R3 cmpA writable", {16'b0, rv}, 32'h1234);
        reg_wr(2'd3, 16'h0000);
        reg_rd(2'd3); check("R12 disarmed", {16'b0, rv}, 0);
        reg_wr(2'd1, CA);
        reg_wr(2'd2, CB);
        reg_rd(2'd2); check("R2 cmpB", {16'b0, rv}, {16'b0, CB});

        // R4 R5 R10 R7: sweep of all mode codes, force, begin trace
        for (int m = 0; m < 16; m++) begin
            for (int p = 0; p < 6; p++) begin
                for (int dv = 0; dv < 2; dv++) begin
                    logic [DW-1:0] d;
                    logic e;
                    d = (dv == 0) ? 8'h60 : 8'h11;
                    e = exp1(m, probes[p], d);
                    reg_wr(2'd0, 16'h0040 | 16'(m));
                    reg_wr(2'd3, 16'h0001);
                    drive(1, 0, probes[p], d, 0, 0);
                    if (m > 8) check("R5 no trigger", {31'b0, s_trig}, 0);
                    else check("R4 R10 trigger", {31'b0, s_trig}, {31'b0, e});
                    check("R7 R8 fifo_we", {31'b0, s_we}, {31'b0, e && (m == 3)});
                    if (e && m == 3) check("R7 event data", {16'b0, s_wd}, {24'b0, d});
                    reg_wr(2'd3, 16'h0000);
                end
            end
        end

        // R6 A then B, then R8 begin capture
        reg_wr(2'd0, 16'h0042);
        reg_wr(2'd3, 16'h0001);
        drive(1, 0, CB, 8'h0, 0, 0); check("R6 B before A", {31'b0, s_trig}, 0);
        drive(1, 0, CA, 8'h0, 0, 0); check("R6 A arms sequence", {31'b0, s_trig}, 0);
        drive(1, 0, 16'h0050, 8'h0, 0, 0); check("R6 other addr", {31'b0, s_trig}, 0);
        drive(1, 0, CB, 8'h0, 0, 0);
        check("R6 B after A", {31'b0, s_trig}, 1);
        check("R8 trigger access not stored", {31'b0, s_we}, 0);
        for (int i = 0; i < 8; i++) begin
            drive(1, 0, 16'h0100 + 16'(i), 8'h0, 0, 0);
            check("R8 capture we", {31'b0, s_we}, 1);
            check("R8 capture addr", {16'b0, s_wd}, 32'h0100 + i);
            check("R8 still armed", {31'b0, s_armed}, 1);
        end
        drive(1, 0, 16'h0200, 8'h0, 0, 0);
        check("R8 disarmed when full", {31'b0, s_armed}, 0);
        check("R8 no write after full", {31'b0, s_we}, 0);
        check("R8 done", {31'b0, done}, 1);

        // R6 disarm clears the sequence flag
        reg_wr(2'd3, 16'h0001);
        reg_rd(2'd3); check("R12 arm clears done", {16'b0, rv}, 1);
        drive(1, 0, CA, 8'h0, 0, 0);
        reg_wr(2'd3, 16'h0000);
        reg_wr(2'd3, 16'h0001);
        drive(1, 0, CB, 8'h0, 0, 0); check("R6 flag cleared by disarm", {31'b0, s_trig}, 0);
        reg_wr(2'd3, 16'h0000);

        // R9 end trace
        reg_wr(2'd0, 16'h0000);
        reg_wr(2'd3, 16'h0001);
        for (int i = 0; i < 10; i++) begin
            drive(1, 0, 16'h0200 + 16'(i), 8'h0, 0, 0);
            check("R9 circular we", {31'b0, s_we}, 1);
            check("R9 circular addr", {16'b0, s_wd}, 32'h0200 + i);
            check("R9 no trigger yet", {31'b0, s_trig}, 0);
        end
        drive(1, 0, CA, 8'h0, 0, 0);
        check("R9 trigger", {31'b0, s_trig}, 1);
        check("R9 trigger access stored", {31'b0, s_we}, 1);
        check("R9 trigger addr", {16'b0, s_wd}, {16'b0, CA});
        drive(1, 0, 16'h0300, 8'h0, 0, 0);
        check("R9 disarmed", {31'b0, s_armed}, 0);
        check("R9 no write after stop", {31'b0, s_we}, 0);
        reg_rd(2'd3); check("R9 status done", {16'b0, rv}, 2);
        reg_wr(2'd3, 16'h0000);
        reg_rd(2'd3); check("R12 disarm keeps done", {16'b0, rv}, 2);

        // R7 A then event-only B, begin bit 0 ignored
        reg_wr(2'd0, 16'h0004);
        reg_wr(2'd3, 16'h0001);
        drive(1, 0, CB, 8'h11, 0, 0);
        check("R7 B before A", {31'b0, s_we}, 0);
        drive(1, 0, CA, 8'h22, 0, 0);
        check("R7 A no event", {31'b0, s_trig}, 0);
        check("R7 A no write", {31'b0, s_we}, 0);
        for (int k = 0; k < 8; k++) begin
            drive(1, 0, CB, 8'h20 + 8'(k), 0, 0);
            check("R7 event trig", {31'b0, s_trig}, 1);
            check("R7 event we", {31'b0, s_we}, 1);
            check("R7 event data", {16'b0, s_wd}, 32'h20 + k);
        end
        drive(0, 0, '0, '0, 0, 0);
        check("R7 disarmed after 8", {31'b0, s_armed}, 0);
        check("R7 done", {31'b0, done}, 1);

        // R11 tag mode
        reg_wr(2'd0, 16'h00C0);
        reg_wr(2'd3, 16'h0001);
        drive(1, 1, CA, 8'h0, 0, 0); check("R11 fetch alone", {31'b0, s_trig}, 0);
        drive(0, 0, '0, '0, 0, 0); check("R11 idle", {31'b0, s_trig}, 0);
        drive(0, 0, '0, '0, 1, 0); check("R11 exec fires", {31'b0, s_trig}, 1);
        reg_wr(2'd3, 16'h0000);
        reg_wr(2'd3, 16'h0001);
        drive(1, 0, CA, 8'h0, 0, 0); check("R11 data access no tag", {31'b0, s_trig}, 0);
        drive(0, 0, '0, '0, 1, 0); check("R11 exec without tag", {31'b0, s_trig}, 0);
        drive(1, 1, CA, 8'h0, 0, 0);
        drive(0, 0, '0, '0, 0, 1); check("R11 flush", {31'b0, s_trig}, 0);
        drive(0, 0, '0, '0, 1, 0); check("R11 exec after flush", {31'b0, s_trig}, 0);
        drive(1, 1, CA, 8'h0, 1, 0); check("R11 exec with new fetch", {31'b0, s_trig}, 0);
        drive(0, 0, '0, '0, 1, 0); check("R11 exec of new tag", {31'b0, s_trig}, 1);
        reg_wr(2'd3, 16'h0000);

        // R11 R7 tagged event-only data
        reg_wr(2'd0, 16'h0083);
        reg_wr(2'd3, 16'h0001);
        drive(1, 1, CB, 8'h5A, 0, 0); check("R11 tagged event waits", {31'b0, s_we}, 0);
        drive(0, 0, '0, '0, 1, 0);
        check("R11 tagged event we", {31'b0, s_we}, 1);
        check("R7 tagged event data", {16'b0, s_wd}, 32'h5A);
        reg_wr(2'd3, 16'h0000);

        drive(0, 0, '0, '0, 0, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule